// File: doc/BRIEF.md
# Nickel-and-Dime Credit Controller

This block is the control state machine of a single-slot item dispenser. The item costs 15 cents and only nickels and dimes are accepted. The block receives a one-cycle pulse for each coin that has already been validated upstream. It adds each coin's value to a running credit and raises a release output once the credit reaches the price. No change is given. Any overpayment is absorbed by clamping the credit at the price.

The credit is held in a small binary register that counts in 5-cent units, so 0, 5, 10 and 15 cents map to codes 00, 01, 10 and 11. The block is a Moore machine. The release output depends only on the stored credit and comes straight from a flop. Once the full-credit state is reached, the machine stays there whatever the coin inputs do, until the active-low reset clears it. A nickel and a dime pulsed in the same cycle cannot happen in a correct system. The block handles it predictably by ignoring both pulses.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `credit_o` is 0 and `release_o` is 0.
- R2: A cycle with `nickel_i`=1 and `dime_i`=0, sampled on a rising edge, adds 1 to `credit_o` (5-cent units) after that edge, when the result does not exceed 3.
- R3: A cycle with `dime_i`=1 and `nickel_i`=0 adds 2 to `credit_o` after that edge, when the result does not exceed 3.
- R4: A cycle with neither coin input high leaves `credit_o` unchanged.
- R5: A cycle with both coin inputs high is ignored, and `credit_o` is unchanged.
- R6: A coin that would take the credit past 3 sets `credit_o` to 3 (code 11, 15 cents). A dime at credit 2 gives 3.
- R7: `release_o` is 1 exactly when `credit_o` equals 3, with no combinational path from the coin inputs.
- R8: Once `credit_o` is 3, it stays 3 and `release_o` stays 1 for any coin inputs until reset.
- R9: Asserting reset from any credit value (0 to 3) returns `credit_o` to 0 and `release_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| release_o | output | 1 | High while full credit is held |
| credit_o | output | CREDIT_W (2) | Current credit in 5-cent units |

## Verification
The step properties assume that each coin input is a synchronous level sampled once per rising edge. They do not assume one edge per physical coin. The bench therefore changes inputs only on falling edges and holds each pulse for exactly one clock, so every pulse counts once. The clash property assumes nothing about how often both inputs rise together, and the bench drives that case on purpose at zero and non-zero credit. Reset is applied only at falling edges, away from the sampling edge.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Classified coin event for one cycle
    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2,
        COIN_CLASH  = 2'd3
    } coin_e;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);

    always_comb begin
        unique case ({dime_i, nickel_i})
            2'b01:   coin_o = COIN_NICKEL;
            2'b10:   coin_o = COIN_DIME;
            2'b11:   coin_o = COIN_CLASH;
            default: coin_o = COIN_NONE;
        endcase
    end

endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS  = 3,
    parameter int NICKEL_UNITS = 1,
    parameter int DIME_UNITS   = 2,
    parameter int CREDIT_W     = 2
) (
    input  logic [CREDIT_W-1:0] credit_i,
    input  coin_e               coin_i,
    output logic [CREDIT_W-1:0] credit_o
);

    localparam int SUM_W = CREDIT_W + 3;

    logic [SUM_W-1:0] add_units;
    logic [SUM_W-1:0] sum;

    always_comb begin
        unique case (coin_i)
            COIN_NICKEL: add_units = SUM_W'(NICKEL_UNITS);
            COIN_DIME:   add_units = SUM_W'(DIME_UNITS);
            default:     add_units = '0;   // none, or clash ignored
        endcase
        sum = SUM_W'(credit_i) + add_units;
        if (sum >= SUM_W'(PRICE_UNITS)) begin
            credit_o = CREDIT_W'(PRICE_UNITS);
        end else begin
            credit_o = sum[CREDIT_W-1:0];
        end
    end

endmodule

// File: rtl/vend_release_decode.sv
module vend_release_decode #(
    parameter int PRICE_UNITS = 3,
    parameter int CREDIT_W    = 2
) (
    input  logic [CREDIT_W-1:0] credit_i,
    output logic                release_o
);

    always_comb begin
        release_o = (credit_i == CREDIT_W'(PRICE_UNITS));
    end

endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
    import vend_pkg::*;
#(
    parameter  int PRICE_UNITS  = 3,
    parameter  int NICKEL_UNITS = 1,
    parameter  int DIME_UNITS   = 2,
    localparam int CREDIT_W     = $clog2(PRICE_UNITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nickel_i,
    input  logic                dime_i,
    output logic                release_o,
    output logic [CREDIT_W-1:0] credit_o
);

    typedef struct packed {
        logic [CREDIT_W-1:0] credit;
        logic                release_flag;
    } ctrl_state_t;

    ctrl_state_t         st_d, st_q;
    coin_e               coin;
    logic [CREDIT_W-1:0] credit_nxt;
    logic                release_nxt;

    vend_coin_decode u_coin (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_credit_next #(
        .PRICE_UNITS  (PRICE_UNITS),
        .NICKEL_UNITS (NICKEL_UNITS),
        .DIME_UNITS   (DIME_UNITS),
        .CREDIT_W     (CREDIT_W)
    ) u_next (
        .credit_i (st_q.credit),
        .coin_i   (coin),
        .credit_o (credit_nxt)
    );

    vend_release_decode #(
        .PRICE_UNITS (PRICE_UNITS),
        .CREDIT_W    (CREDIT_W)
    ) u_rel (
        .credit_i  (credit_nxt),
        .release_o (release_nxt)
    );

    always_comb begin
        st_d              = st_q;
        st_d.credit       = credit_nxt;
        st_d.release_flag = release_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign credit_o  = st_q.credit;
    assign release_o = st_q.release_flag;

    // R1: a reset seen at one edge leaves zero credit at the next
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (credit_o == '0 && !release_o));

    // R2
    p_nickel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel_i && !dime_i && (int'(credit_o) + NICKEL_UNITS <= PRICE_UNITS))
        |=> int'(credit_o) == int'($past(credit_o)) + NICKEL_UNITS);

    // R3
    p_dime_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dime_i && !nickel_i && (int'(credit_o) + DIME_UNITS <= PRICE_UNITS))
        |=> int'(credit_o) == int'($past(credit_o)) + DIME_UNITS);

    // R4
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel_i && !dime_i) |=> $stable(credit_o));

    // R5
    p_clash_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel_i && dime_i) |=> $stable(credit_o));

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dime_i && !nickel_i && (int'(credit_o) + DIME_UNITS > PRICE_UNITS))
        |=> int'(credit_o) == PRICE_UNITS);

    // R7
    p_release_moore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        release_o == (int'(credit_o) == PRICE_UNITS));

    // R8
    p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (release_o && int'(credit_o) == PRICE_UNITS));

endmodule

// File: tb/tb_vend_credit_ctrl.sv
`timescale 1ns/1ps
module tb_vend_credit_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nickel = 1'b0;
    logic       dime = 1'b0;
    logic       rel;
    logic [1:0] credit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vend_credit_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .nickel_i  (nickel),
        .dime_i    (dime),
        .release_o (rel),
        .credit_o  (credit)
    );

    task automatic check(input string req, input int act_c, input int exp_c);
        n_checks++;
        if (act_c != exp_c || rel !== (exp_c == 3)) begin
            n_fail++;
            $display("FAIL %s: credit=%0d release=%0b expected credit=%0d release=%0b",
                     req, act_c, rel, exp_c, (exp_c == 3));
        end
    endtask

    // one clock with the given coin inputs, result sampled at the next falling edge
    task automatic coin(input logic n, input logic d);
        @(negedge clk);
        nickel = n;
        dime   = d;
        @(negedge clk);
        nickel = 1'b0;
        dime   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R1/R9 reset", int'(credit), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_nnn();
        do_reset();
        coin(1, 0); check("R2 N", int'(credit), 1);
        coin(1, 0); check("R2 NN", int'(credit), 2);
        coin(1, 0); check("R2/R7 NNN", int'(credit), 3);
    endtask

    task automatic t_nd();
        do_reset();
        coin(1, 0); coin(0, 1); check("R3 ND", int'(credit), 3);
    endtask

    task automatic t_dn();
        do_reset();
        coin(0, 1); check("R3/R7 D", int'(credit), 2);
        coin(1, 0); check("R2 DN", int'(credit), 3);
    endtask

    task automatic t_dd();
        do_reset();
        coin(0, 1); coin(0, 1); check("R6 DD", int'(credit), 3);
    endtask

    task automatic t_nnd();
        do_reset();
        coin(1, 0); coin(1, 0); coin(0, 1); check("R6 NND", int'(credit), 3);
    endtask

    task automatic t_idle();
        do_reset();
        coin(1, 0);
        coin(0, 0); coin(0, 0); check("R4 idle at 1", int'(credit), 1);
        coin(1, 0);
        coin(0, 0); check("R4 idle at 2", int'(credit), 2);
    endtask

    task automatic t_clash();
        do_reset();
        coin(1, 1); check("R5 clash at 0", int'(credit), 0);
        coin(1, 0);
        coin(1, 1); check("R5 clash at 1", int'(credit), 1);
        coin(0, 1);
        coin(1, 1); check("R5 clash at 3", int'(credit), 3);
    endtask

    task automatic t_sticky();
        do_reset();
        coin(0, 1); coin(1, 0);
        for (int i = 0; i < 4; i++) begin
            coin(logic'(i[0]), logic'(i[1]));
            check("R8 sticky", int'(credit), 3);
        end
    endtask

    task automatic t_reset_any();
        for (int s = 0; s < 4; s++) begin
            do_reset();
            for (int k = 0; k < s; k++) coin(1, 0);
            check("R9 reach state", int'(credit), s);
            do_reset();
            @(negedge clk);
            check("R9 after reset", int'(credit), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(credit), 0);
        rst_n = 1'b1;
        t_nnn();
        t_nd();
        t_dn();
        t_dd();
        t_nnd();
        t_idle();
        t_clash();
        t_sticky();
        t_reset_any();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule